// File: doc/BRIEF.md
# Prescaled Timer Counter with Coherent Byte Reads

This block is the counting core of a small microcontroller timer. A 16-bit up-counter advances on enable pulses from a prescaler. The prescaler divides the bus clock by a power of two from 1 to 64, or it passes on rising edges of an external clock pin once they have been synchronized. A 3-bit source code in a control register picks the source. Writing a one to a self-clearing bit in the same register clears the count and the prescaler divider.

Software reads the 16-bit count over an 8-bit register port as two read-only bytes. Reading the high byte freezes a copy of the low byte. The next low-byte read returns that copy and releases it, so the high byte and the low byte always come from the same instant. While the copy is frozen, further high-byte reads do not refresh it. If the low byte is never read, the copy stays frozen.

Register map (`addr`): 0 = control, 1 = count high byte, 2 = count low byte, 3 = reads as zero. The port has no wait states. `rdata` shows the addressed register in the same cycle, and the side effects of a read take place at the clock edge that ends the read cycle.

Top module: `tmr_cnt_top`

## Requirements
- R1: With source code k in 0..6 (control bits [2:0]), the count equals floor(N / 2^k) modulo 65536, where N is the number of clock edges since the edge that cleared it.
- R2: With source code 7, each rising edge of `ext_clk` adds exactly one to the count. The increment lands on the third clock edge after the rise. The bus clock alone never advances the count in this mode.
- R3: Control bits [2:0] read back the last value written. Control bits [7:3] always read as 0.
- R4: A read of address 1 returns count bits [15:8] and captures count bits [7:0]. The next read of address 2 returns the captured byte.
- R5: While a byte is captured, further reads of address 1 do not replace it. A read of address 2 releases the capture, so the read of address 2 after it returns the live low byte.
- R6: A captured low byte stays unchanged for any number of cycles until address 2 is read.
- R7: Writes to addresses 1 and 2 change neither the count nor its progression.
- R8: While reset is high, the count is zero and the control register reads zero. Reset also drops any captured low byte.
- R9: Writing control with bit 4 set clears the count and the prescaler divider at that edge. Bit 4 itself always reads back as 0.
- R10: The count wraps from 0xFFFF to 0x0000 and keeps counting.
- R11: With no byte captured, a read of address 2 returns the live count bits [7:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe; side effects take place at the closing edge |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| ext_clk | input | 1 | External count clock, asynchronous to `clk` |
| rdata | output | 8 | Read data for `addr`, combinational |

## Verification
Nearly every internal fault is visible at the byte ports. A divider that ticks at the wrong rate shifts the count away from floor(N/2^k) within a few cycles at low divisions, and within 64 cycles at the highest division. A capture register that reloads or releases at the wrong moment shows up on the very next low-byte read as a value that does not match the high byte read earlier. A faulty synchronizer or edge detector changes the count of external edges after the first pulse. A missing wrap shows up one cycle after the count reaches 0xFFFF.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int SEL_W   = 3;
    localparam int DIV_W   = 6;
    localparam int ADDR_W  = 2;
    localparam int CLR_BIT = 4;
    localparam int SYNC_N  = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_CNT_HI = 2'd1,
        REG_CNT_LO = 2'd2,
        REG_SPARE  = 2'd3
    } reg_addr_e;

    typedef enum logic [SEL_W-1:0] {
        SRC_DIV1  = 3'd0,
        SRC_DIV2  = 3'd1,
        SRC_DIV4  = 3'd2,
        SRC_DIV8  = 3'd3,
        SRC_DIV16 = 3'd4,
        SRC_DIV32 = 3'd5,
        SRC_DIV64 = 3'd6,
        SRC_EXT   = 3'd7
    } clk_src_e;

    typedef struct packed {
        logic rd_hi;
        logic rd_lo;
        logic wr_ctrl;
        logic clr;
    } bus_evt_t;

    // Low `sel` bits set: divider reaches all ones once per 2^sel cycles
    function automatic logic [DIV_W-1:0] div_mask(input logic [SEL_W-1:0] sel);
        logic [DIV_W-1:0] m;
        for (int i = 0; i < DIV_W; i++) begin
            m[i] = (i < int'(sel));
        end
        return m;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int DIV_BITS   = DIV_W,
    parameter int SEL_BITS   = SEL_W,
    parameter int SYNC_DEPTH = SYNC_N
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  clk_src_e            src,
    input  logic                ext_clk,
    output logic                tick
);

    localparam int CHAIN_W = SYNC_DEPTH + 1;

    logic [DIV_BITS-1:0] div_q;
    logic [CHAIN_W-1:0]  sync_q;
    logic [DIV_BITS-1:0] mask;
    logic                ext_rise;
    logic                div_tick;

    // Free-running divider, cleared with the counter
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Synchronizer plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[CHAIN_W-2:0], ext_clk};
        end
    end

    always_comb begin
        mask     = div_mask(src);
        div_tick = ((div_q & mask) == mask);
        ext_rise = sync_q[SYNC_DEPTH-1] & ~sync_q[SYNC_DEPTH];
        tick     = (src == SRC_EXT) ? ext_rise : div_tick;
    end

    // R2
    ext_single_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && src == SRC_EXT) |=> !(tick && src == SRC_EXT))
        else $error("external tick lasted more than one cycle");

    // R1
    div2_alt_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && src == SRC_DIV2) |=> !(tick && src == SRC_DIV2))
        else $error("divide-by-2 ticked on consecutive cycles");

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int WIDTH = tmr_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    output logic [WIDTH-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0))
        else $error("count not cleared");

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !tick) |=> $stable(count))
        else $error("count moved without a tick");

    // R10
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && tick && count == '1) |=> (count == '0))
        else $error("count did not wrap to zero");

endmodule

// File: rtl/tmr_read_latch.sv
module tmr_read_latch #(
    parameter int WIDTH = tmr_pkg::BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             release_i,
    input  logic [WIDTH-1:0] live_lo,
    output logic [WIDTH-1:0] lo_view
);

    logic             held_q;
    logic [WIDTH-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            hold_q <= '0;
        end else if (release_i) begin
            held_q <= 1'b0;
        end else if (capture && !held_q) begin
            held_q <= 1'b1;
            hold_q <= live_lo;
        end
    end

    assign lo_view = held_q ? hold_q : live_lo;

    // R5
    hold_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (held_q && !release_i) |=> (held_q && $stable(hold_q)))
        else $error("captured byte changed before release");

    // R4
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (capture && !held_q && !release_i) |=> (held_q && hold_q == $past(live_lo)))
        else $error("capture missed the live low byte");

    // R11
    release_chk: assert property (@(posedge clk) disable iff (rst)
        release_i |=> !held_q)
        else $error("low read did not release capture");

endmodule

// File: rtl/tmr_cnt_top.sv
module tmr_cnt_top
    import tmr_pkg::*;
#(
    parameter int COUNT_W = CNT_W,
    parameter int DATA_W  = BYTE_W,
    parameter int AW      = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ext_clk,
    output logic [DATA_W-1:0] rdata
);

    localparam int HALF_W = COUNT_W / 2;

    reg_addr_e          reg_a;
    bus_evt_t           evt;
    clk_src_e           src_q;
    logic               tick;
    logic [COUNT_W-1:0] count;
    logic [HALF_W-1:0]  lo_view;

    assign reg_a = reg_addr_e'(addr);

    always_comb begin
        evt.rd_hi   = rd_en && (reg_a == REG_CNT_HI);
        evt.rd_lo   = rd_en && (reg_a == REG_CNT_LO);
        evt.wr_ctrl = wr_en && (reg_a == REG_CTRL);
        evt.clr     = evt.wr_ctrl && wdata[CLR_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= SRC_DIV1;
        end else if (evt.wr_ctrl) begin
            src_q <= clk_src_e'(wdata[SEL_W-1:0]);
        end
    end

    tmr_prescaler #(
        .DIV_BITS   (DIV_W),
        .SEL_BITS   (SEL_W),
        .SYNC_DEPTH (SYNC_N)
    ) u_presc (
        .clk     (clk),
        .rst     (rst),
        .clr     (evt.clr),
        .src     (src_q),
        .ext_clk (ext_clk),
        .tick    (tick)
    );

    tmr_counter #(
        .WIDTH (COUNT_W)
    ) u_count (
        .clk   (clk),
        .rst   (rst),
        .clr   (evt.clr),
        .tick  (tick),
        .count (count)
    );

    tmr_read_latch #(
        .WIDTH (HALF_W)
    ) u_latch (
        .clk       (clk),
        .rst       (rst),
        .capture   (evt.rd_hi),
        .release_i (evt.rd_lo),
        .live_lo   (count[HALF_W-1:0]),
        .lo_view   (lo_view)
    );

    always_comb begin
        rdata = '0;
        unique case (reg_a)
            REG_CTRL:   rdata[SEL_W-1:0] = src_q;
            REG_CNT_HI: rdata = DATA_W'(count[COUNT_W-1:HALF_W]);
            REG_CNT_LO: rdata = DATA_W'(lo_view);
            default:    rdata = '0;
        endcase
    end

    // R3
    ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_a == REG_CTRL) |-> (rdata[DATA_W-1:SEL_W] == '0))
        else $error("control upper bits not zero");

    // R7
    cnt_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_a != REG_CTRL && !tick) |=> $stable(count))
        else $error("write to count byte altered the count");

    // R8
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (count == '0 && src_q == SRC_DIV1))
        else $error("reset did not clear state");

endmodule

// File: tb/test_tmr_cnt_top.sv
module test_tmr_cnt_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic       ext_clk = 1'b0;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int clr_cyc = 0;
    int div_now = 1;
    bit done = 1'b0;

    tmr_cnt_top i_tmr_cnt_top (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .ext_clk (ext_clk),
        .rdata   (rdata)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int model(input int n);
        return (n / div_now) % 65536;
    endfunction

    task automatic rd(input logic [1:0] a, output logic [7:0] d, output int n);
        @(negedge clk);
        rd_en = 1'b1;
        addr  = a;
        #1;
        d = rdata;
        n = cyc - clr_cyc;
        @(posedge clk);
        #1;
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = v;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (a == 2'd0) begin
            if (v[2:0] != 3'd7) div_now = 1 << v[2:0];
            if (v[4]) clr_cyc = cyc;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        logic [7:0] d, h;
        int n, nh;

        // Reset state: R8
        idle(3);
        @(negedge clk);
        addr = 2'd0; #1; check("R8 ctrl in reset", rdata, 0);
        addr = 2'd1; #1; check("R8 hi in reset", rdata, 0);
        addr = 2'd2; #1; check("R8 lo in reset", rdata, 0);
        rst = 1'b0;

        // Control readback: R3, R9 bit 4 reads zero
        wr(2'd0, 8'hEB);
        rd(2'd0, d, n);
        check("R3 ctrl readback masks upper bits", d, 8'h03);
        wr(2'd0, 8'h15);
        rd(2'd0, d, n);
        check("R9 clear bit reads 0", d, 8'h05);

        // Sweep all bus divisions: R1, R9, R11, R4
        for (int k = 0; k < 7; k++) begin
            wr(2'd0, 8'h10 | 8'(k));
            rd(2'd2, d, n);
            check("R9 count right after clear", d, model(n) & 255);
            idle(1500 + 37 * k);
            rd(2'd2, d, n);
            check("R11 R1 live low byte", d, model(n) & 255);
            rd(2'd1, h, nh);
            check("R1 high byte", h, (model(nh) >> 8) & 255);
            idle(5 + k);
            rd(2'd2, d, n);
            check("R4 captured low byte", d, model(nh) & 255);
            rd(2'd0, d, n);
            check("R3 select readback", d, k);
        end

        // Repeated high reads keep the first capture: R5
        wr(2'd0, 8'h10);
        idle(300);
        rd(2'd1, h, nh);
        idle(40);
        rd(2'd1, h, n);
        check("R5 second high read is live", h, (model(n) >> 8) & 255);
        idle(40);
        rd(2'd2, d, n);
        check("R5 low keeps first capture", d, model(nh) & 255);
        idle(3);
        rd(2'd2, d, n);
        check("R5 low live after release", d, model(n) & 255);

        // Capture held indefinitely: R6
        rd(2'd1, h, nh);
        idle(3000);
        rd(2'd2, d, n);
        check("R6 capture after long wait", d, model(nh) & 255);

        // Writes to count bytes ignored: R7
        wr(2'd0, 8'h12);
        idle(100);
        wr(2'd1, 8'hAA);
        wr(2'd2, 8'h55);
        rd(2'd2, d, n);
        check("R7 low after count writes", d, model(n) & 255);
        rd(2'd1, h, nh);
        check("R7 high after count writes", h, (model(nh) >> 8) & 255);
        rd(2'd2, d, n);

        // Wrap: R10
        wr(2'd0, 8'h10);
        idle(65600);
        rd(2'd1, h, nh);
        check("R10 high after wrap", h, (model(nh) >> 8) & 255);
        rd(2'd2, d, n);
        check("R10 low after wrap", d, model(nh) & 255);

        // External clock: R2
        wr(2'd0, 8'h17);
        idle(50);
        rd(2'd2, d, n);
        check("R2 no bus counting in external mode", d, 0);
        for (int p = 0; p < 12; p++) begin
            @(negedge clk); ext_clk = 1'b1;
            idle(3);
            @(negedge clk); ext_clk = 1'b0;
            idle(3);
            if (p == 4) begin
                rd(2'd2, d, n);
                check("R2 count after 5 edges", d, 5);
            end
        end
        idle(6);
        rd(2'd2, d, n);
        check("R2 count after 12 edges", d, 12);
        rd(2'd1, d, n);
        check("R2 high byte in external mode", d, 0);

        // Reset drops capture: R8
        wr(2'd0, 8'h10);
        idle(600);
        rd(2'd1, h, nh);
        @(negedge clk); rst = 1'b1;
        idle(2);
        @(negedge clk);
        addr = 2'd0; #1; check("R8 ctrl cleared by reset", rdata, 0);
        addr = 2'd1; #1; check("R8 hi cleared by reset", rdata, 0);
        rst = 1'b0;
        clr_cyc = cyc;
        div_now = 1;
        idle(20);
        rd(2'd2, d, n);
        check("R8 capture dropped by reset", d, model(n) & 255);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(2_000_000 * 1ns);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule